// File: doc/BRIEF.md
# Remote-Upgrade Serial Control Register

This block sits between user logic and the circuitry that manages in-field reconfiguration. It keeps two registers of equal width on one dedicated clock. The first is a working register that can be loaded in parallel from a status bus or moved serially one bit per cycle. The second is a control register that takes a full copy of the working register on request and otherwise keeps its contents.

Two mode pins pick the operation on each rising edge, with a fixed priority. While the shift select is high, the working register shifts and the capture select has no effect. While the shift select is low, the capture select chooses between two operations. When it is high, the working register loads from the status bus. When it is low, the working register is copied into the control register.

The block also turns two active-low requests into registered outputs. A falling edge on the watchdog-restart input gives a single one-cycle restart pulse. A low level on the reconfiguration input gives a reconfiguration request, but only while the feature enable is set.

Top module: `upgrade_serial_ctl`

## Requirements
- R1: A synchronous active-high reset clears the working register, the control register, the restart pulse and the reconfiguration request on the next rising edge. The bench checks `ser_out`, `ctrl_out`, `wd_restart_pulse` and `reconf_req` all at 0, whatever the other inputs do while reset is held.
- R2: When `mode_shift` is 1, each rising edge moves the working register one place toward bit 0 and writes `ser_in` into the top bit. `mode_capture` has no effect while `mode_shift` is 1.
- R3: When `mode_shift` is 0 and `mode_capture` is 1, a rising edge loads the working register with `status_in`.
- R4: When `mode_shift` is 0 and `mode_capture` is 0, a rising edge copies the working register into the control register (`ctrl_out`). The working register keeps its value.
- R5: `ser_out` always shows bit 0 of the working register. After each shift edge it shows the bit that was in position 1 before that edge.
- R6: In shift and capture operations, `ctrl_out` keeps its value.
- R7: A rising edge that samples `wd_restart_n` low, after the previous edge sampled it high, makes `wd_restart_pulse` high for exactly one cycle. A further pulse needs the input to go high and then low again. The register that holds the previous sample starts at high after reset.
- R8: After each rising edge, `reconf_req` is 1 when that edge sampled `reconf_n` at 0 and `reconf_en` at 1, and 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_shift | input | 1 | 1 selects serial shift; has priority over `mode_capture` |
| mode_capture | input | 1 | With `mode_shift` low: 1 captures status, 0 updates control |
| ser_in | input | 1 | Serial data entering the top bit of the working register |
| status_in | input | W | Parallel status loaded during capture |
| ser_out | output | 1 | Bit 0 of the working register |
| ctrl_out | output | W | Contents of the control register |
| wd_restart_n | input | 1 | Watchdog restart, acts on a falling edge |
| wd_restart_pulse | output | 1 | One-cycle watchdog restart request |
| reconf_n | input | 1 | Reconfiguration request, active low |
| reconf_en | input | 1 | Remote-upgrade feature enable |
| reconf_req | output | 1 | Registered reconfiguration request |

## Verification
The bench walks every value of a six-bit status word through capture, then update, then a complete serial readout, then a second update. The capture select toggles during the shifts, so a design that let capture win over shift would load the inverted status word and give a wrong serial stream. A design that shifted toward the wrong end, or fed `ser_in` into bit 0, would give a mismatched `ser_out` sequence and a wrong second update. The bench then cycles through every combination of the mode, restart, reconfiguration and enable inputs. Restart held low for four cycles catches a level-sensitive detector, which pulses more than once. Toggling the enable catches an ungated request. A reset applied in the middle of a run, with every request input active, catches registers left out of the reset.

// File: rtl/upgrade_serial_pkg.sv
`timescale 1ns/1ps
package upgrade_serial_pkg;

    // Operation chosen for the working/control register pair on a clock edge
    typedef enum logic [1:0] {
        OP_UPDATE  = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } op_e;

endpackage

// File: rtl/usc_mode_decode.sv
`timescale 1ns/1ps
module usc_mode_decode (
    input  logic                    sel_shift,
    input  logic                    sel_capture,
    output upgrade_serial_pkg::op_e op
);
    import upgrade_serial_pkg::*;

    // Shift select dominates; capture select only matters when it is low
    always_comb begin
        if (sel_shift) begin
            op = OP_SHIFT;
        end else if (sel_capture) begin
            op = OP_CAPTURE;
        end else begin
            op = OP_UPDATE;
        end
    end

endmodule

// File: rtl/usc_shift_path.sv
`timescale 1ns/1ps
module usc_shift_path #(
    parameter int W = 22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  upgrade_serial_pkg::op_e op,
    input  logic                    ser_in,
    input  logic [W-1:0]            status_in,
    output logic [W-1:0]            shift_word,
    output logic [W-1:0]            hold_word
);
    import upgrade_serial_pkg::*;

    typedef struct packed {
        logic [W-1:0] work;
        logic [W-1:0] hold;
    } path_t;

    path_t path_d, path_q;

    always_comb begin
        path_d = path_q;
        case (op)
            OP_SHIFT: begin
                // serial bit enters at the top, bit 0 leaves
                path_d.work = W'({ser_in, path_q.work} >> 1);
            end
            OP_CAPTURE: begin
                path_d.work = status_in;
            end
            OP_UPDATE: begin
                path_d.hold = path_q.work;
            end
            default: begin
                path_d = path_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= '0;
        end else begin
            path_q <= path_d;
        end
    end

    assign shift_word = path_q.work;
    assign hold_word  = path_q.hold;

endmodule

// File: rtl/usc_request.sv
`timescale 1ns/1ps
module usc_request (
    input  logic clk,
    input  logic rst,
    input  logic wd_n,
    input  logic cfg_n,
    input  logic cfg_en,
    output logic wd_pulse,
    output logic cfg_req
);
    typedef struct packed {
        logic wd_last;
        logic wd_pulse;
        logic cfg_req;
    } req_t;

    localparam req_t REQ_RESET = '{wd_last: 1'b1, wd_pulse: 1'b0, cfg_req: 1'b0};

    req_t req_d, req_q;

    always_comb begin
        req_d          = req_q;
        req_d.wd_last  = wd_n;
        // high-to-low transition between consecutive samples
        req_d.wd_pulse = req_q.wd_last & ~wd_n;
        req_d.cfg_req  = ~cfg_n & cfg_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= REQ_RESET;
        end else begin
            req_q <= req_d;
        end
    end

    assign wd_pulse = req_q.wd_pulse;
    assign cfg_req  = req_q.cfg_req;

endmodule

// File: rtl/upgrade_serial_ctl.sv
`timescale 1ns/1ps
module upgrade_serial_ctl #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_shift,
    input  logic         mode_capture,
    input  logic         ser_in,
    input  logic [W-1:0] status_in,
    output logic         ser_out,
    output logic [W-1:0] ctrl_out,
    input  logic         wd_restart_n,
    output logic         wd_restart_pulse,
    input  logic         reconf_n,
    input  logic         reconf_en,
    output logic         reconf_req
);
    upgrade_serial_pkg::op_e op;
    logic [W-1:0]            shift_word;

    usc_mode_decode u_decode (
        .sel_shift   (mode_shift),
        .sel_capture (mode_capture),
        .op          (op)
    );

    usc_shift_path #(.W(W)) u_path (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .ser_in     (ser_in),
        .status_in  (status_in),
        .shift_word (shift_word),
        .hold_word  (ctrl_out)
    );

    usc_request u_req (
        .clk      (clk),
        .rst      (rst),
        .wd_n     (wd_restart_n),
        .cfg_n    (reconf_n),
        .cfg_en   (reconf_en),
        .wd_pulse (wd_restart_pulse),
        .cfg_req  (reconf_req)
    );

    assign ser_out = shift_word[0];

endmodule

// File: rtl/usc_checker.sv
`timescale 1ns/1ps
module usc_checker #(
    parameter int W = 22
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_shift,
    input logic         mode_capture,
    input logic         ser_in,
    input logic [W-1:0] status_in,
    input logic         ser_out,
    input logic [W-1:0] shift_word,
    input logic [W-1:0] ctrl_out,
    input logic         wd_restart_n,
    input logic         wd_restart_pulse,
    input logic         reconf_n,
    input logic         reconf_en,
    input logic         reconf_req
);

    p_shift_move_r2: assert property (@(posedge clk) disable iff (rst)
        mode_shift |=> shift_word == {$past(ser_in), $past(shift_word[W-1:1])});

    p_capture_load_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_shift && mode_capture) |=> shift_word == $past(status_in));

    p_update_copy_r4: assert property (@(posedge clk) disable iff (rst)
        (!mode_shift && !mode_capture) |=> (ctrl_out == $past(shift_word)) && $stable(shift_word));

    p_serial_next_r5: assert property (@(posedge clk) disable iff (rst)
        mode_shift |=> ser_out == $past(shift_word[1]));

    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_shift || mode_capture) |=> $stable(ctrl_out));

    p_restart_edge_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_restart_n) |=> wd_restart_pulse);

    p_restart_single_r7: assert property (@(posedge clk) disable iff (rst)
        wd_restart_pulse |=> !wd_restart_pulse);

    p_reconf_set_r8: assert property (@(posedge clk) disable iff (rst)
        (!reconf_n && reconf_en) |=> reconf_req);

    p_reconf_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (reconf_n || !reconf_en) |=> !reconf_req);

endmodule

bind upgrade_serial_ctl usc_checker #(.W(W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .mode_shift       (mode_shift),
    .mode_capture     (mode_capture),
    .ser_in           (ser_in),
    .status_in        (status_in),
    .ser_out          (ser_out),
    .shift_word       (shift_word),
    .ctrl_out         (ctrl_out),
    .wd_restart_n     (wd_restart_n),
    .wd_restart_pulse (wd_restart_pulse),
    .reconf_n         (reconf_n),
    .reconf_en        (reconf_en),
    .reconf_req       (reconf_req)
);

// File: tb/upgrade_serial_ctl_test.sv
`timescale 1ns/1ps
module upgrade_serial_ctl_test;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         mode_shift, mode_capture, ser_in;
    logic [W-1:0] status_in;
    logic         ser_out;
    logic [W-1:0] ctrl_out;
    logic         wd_restart_n, wd_restart_pulse;
    logic         reconf_n, reconf_en, reconf_req;

    // bench model
    logic [W-1:0] m_sh, m_hold;
    logic         m_last, m_pulse, m_req;
    int           checks = 0;
    int           fails  = 0;
    bit           done   = 1'b0;

    always #2 clk = ~clk;

    upgrade_serial_ctl #(.W(W)) uut (
        .clk              (clk),
        .rst              (rst),
        .mode_shift       (mode_shift),
        .mode_capture     (mode_capture),
        .ser_in           (ser_in),
        .status_in        (status_in),
        .ser_out          (ser_out),
        .ctrl_out         (ctrl_out),
        .wd_restart_n     (wd_restart_n),
        .wd_restart_pulse (wd_restart_pulse),
        .reconf_n         (reconf_n),
        .reconf_en        (reconf_en),
        .reconf_req       (reconf_req)
    );

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_vec(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_sh = '0; m_hold = '0; m_last = 1'b1; m_pulse = 1'b0; m_req = 1'b0;
    endtask

    // Drive one cycle of inputs, advance the model at the edge, compare after it
    task automatic step(input logic ms, input logic mc, input logic si,
                        input logic [W-1:0] st, input logic wd,
                        input logic rn, input logic en);
        mode_shift = ms; mode_capture = mc; ser_in = si; status_in = st;
        wd_restart_n = wd; reconf_n = rn; reconf_en = en;
        @(posedge clk);
        if (ms)      m_sh = {si, m_sh[W-1:1]};
        else if (mc) m_sh = st;
        else         m_hold = m_sh;
        m_pulse = m_last & ~wd;
        m_last  = wd;
        m_req   = ~rn & en;
        #1;
        chk_bit(ms ? "R2 serial after shift" : (mc ? "R3 serial after capture" : "R5 serial in update"),
                ser_out, m_sh[0]);
        chk_vec((ms || mc) ? "R6 control held" : "R4 control updated", ctrl_out, m_hold);
        chk_bit("R7 restart pulse", wd_restart_pulse, m_pulse);
        chk_bit("R8 reconfiguration request", reconf_req, m_req);
    endtask

    task automatic reset_checks(input string tag);
        chk_bit(tag, ser_out, 1'b0);
        chk_vec(tag, ctrl_out, '0);
        chk_bit(tag, wd_restart_pulse, 1'b0);
        chk_bit(tag, reconf_req, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset with every request input active
        rst = 1'b1; mode_shift = 1'b1; mode_capture = 1'b1; ser_in = 1'b1;
        status_in = '1; wd_restart_n = 1'b0; reconf_n = 1'b0; reconf_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        reset_checks("R1 initial reset");
        wd_restart_n = 1'b1;
        rst = 1'b0;
        model_clear();

        // every status value: capture, update, full serial readout, update
        for (int v = 0; v < (1 << W); v++) begin
            step(1'b0, 1'b1, 1'b0, W'(v), 1'b1, 1'b1, 1'b0);
            step(1'b0, 1'b0, 1'b1, '0, 1'b1, 1'b1, 1'b0);
            chk_vec("R3 captured word via update", ctrl_out, W'(v));
            for (int i = 0; i < W; i++) begin
                // capture select toggles and status is the inverse: both must be ignored
                step(1'b1, 1'(i), 1'((v * 5) >> i), ~W'(v), 1'b1, 1'b1, 1'b0);
            end
            step(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0);
            chk_vec("R2 shifted-in word", ctrl_out, W'(v * 5));
        end

        // all combinations of modes and request inputs, restart held in runs of four
        for (int n = 0; n < 512; n++) begin
            step(1'(n >> 5), 1'(n >> 6), 1'(n), W'(n * 3), 1'(n >> 2), 1'(n >> 3), 1'(n >> 4));
        end

        // restart held low for many cycles: only one pulse
        step(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0);
        chk_bit("R7 pulse on falling edge", wd_restart_pulse, 1'b1);
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0);
            chk_bit("R7 no repeat while low", wd_restart_pulse, 1'b0);
        end

        // reconfiguration gated by enable
        step(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
        chk_bit("R8 gated off", reconf_req, 1'b0);
        step(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b1);
        chk_bit("R8 asserted", reconf_req, 1'b1);

        // fill registers with nonzero data, then reset in the middle of a run
        step(1'b0, 1'b1, 1'b0, 6'h2D, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0);
        chk_vec("R4 update before reset", ctrl_out, 6'h2D);
        step(1'b1, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        #1;
        reset_checks("R1 reset mid-run");
        wd_restart_n = 1'b1;
        rst = 1'b0;
        model_clear();
        step(1'b1, 1'b0, 1'b1, '0, 1'b1, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule